// File: doc/BRIEF.md
# Split Approximate Adder with Hybrid Error Reduction

This block is a combinational two-operand adder of N bits, split into two parts. The upper N-L bits form an exact ripple-carry adder. The lower L bits form a cheap approximate part whose sum bits come from bitwise logic and not from a carry chain. The approximate part also predicts the single carry that enters the exact part. The design suits error-tolerant datapaths such as image filters and accumulators of noisy samples. In those datapaths a small error in the low bits is acceptable in exchange for a much shorter carry path.

A build-time parameter selects the approximation style:
- plain OR of the low bits;
- OR with the carry prediction removed;
- OR with the lowest C sum bits tied high;
- a hybrid mode. This mode places an XOR at the top approximate bit. It then uses the operand pair one position lower to either correct the top two approximate bits or saturate everything beneath them.

The carry-out is the carry leaving the exact part. The block has no clock and no state.

Top module: `approx_split_adder`

## Requirements
- R1: The output bits N-1..L and the carry-out together equal A[N-1:L] + B[N-1:L] + cin, where cin is the predicted carry of the selected mode.
- R2: In plain OR mode (mode code 0), each sum bit i below L equals A[i] | B[i].
- R3: In modes 0, 2 and 3, the predicted carry cin equals A[L-1] & B[L-1].
- R4: In the mode without prediction (mode code 1), cin is 0 for every input, and the lower bits are A[i] | B[i].
- R5: In constant-fill mode (mode code 2), sum bits C-1..0 are 1 for every input, and bits L-1..C equal A[i] | B[i].
- R6: In hybrid mode (mode code 3), when A[L-2] & B[L-2] is 0, sum bit L-1 is A[L-1] ^ B[L-1] and bits L-2..0 are A[i] | B[i].
- R7: In hybrid mode, when A[L-2] and B[L-2] are both 1 and A[L-1] equals B[L-1], sum bit L-1 is 1 and bit L-2 is 0. Bits L-3..0 keep A[i] | B[i].
- R8: In hybrid mode, when A[L-2] and B[L-2] are both 1 and A[L-1] differs from B[L-1], sum bit L-1 is 1 and bits L-2..0 are all 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | N | First operand |
| b_in | input | N | Second operand |
| sum_out | output | N | Approximate sum |
| carry_out | output | 1 | Carry leaving the exact upper part |

## Verification
The bench targets the boundary at bit L-1, where the predicted carry is formed. A wrong carry there shifts the whole upper half by one. A prediction that leaks into the no-prediction mode also shows up as an upper half that is off by one. In hybrid mode, every combination of the operand pairs at L-1 and L-2 is covered. A design that swapped the correction and saturation branches, or that fired the correction without both L-2 bits set, would corrupt the top approximate bits. The constant-fill boundary at bit C is also covered: a fill that is off by one leaves a stray OR bit or overwrites one.

// File: rtl/approx_pkg.sv
package approx_pkg;

    typedef enum logic [1:0] {
        MODE_LOA    = 2'd0,
        MODE_NOAND  = 2'd1,
        MODE_CONST  = 2'd2,
        MODE_HYBRID = 2'd3
    } mode_e;

    function automatic logic fa_sum(input logic x, input logic y, input logic ci);
        return x ^ y ^ ci;
    endfunction

    function automatic logic fa_carry(input logic x, input logic y, input logic ci);
        return (x & y) | (ci & (x ^ y));
    endfunction

endpackage

// File: rtl/approx_lower.sv
module approx_lower
    import approx_pkg::*;
#(
    parameter int    L    = 8,
    parameter mode_e MODE = MODE_HYBRID,
    parameter int    C    = 2
) (
    input  logic [L-1:0] a_lo,
    input  logic [L-1:0] b_lo,
    output logic [L-1:0] s_lo,
    output logic         cin_hi
);

    logic [L-1:0] or_vec;
    assign or_vec = a_lo | b_lo;

    generate
        if (MODE == MODE_NOAND) begin : g_cin_zero
            assign cin_hi = 1'b0;
        end else begin : g_cin_and
            assign cin_hi = a_lo[L-1] & b_lo[L-1];
        end

        if (MODE == MODE_HYBRID) begin : g_hybrid
            logic top_x;
            logic red_on;
            assign top_x  = a_lo[L-1] ^ b_lo[L-1];
            assign red_on = a_lo[L-2] & b_lo[L-2];
            always_comb begin
                s_lo      = or_vec;
                s_lo[L-1] = top_x;
                if (red_on) begin
                    if (!top_x) begin
                        s_lo[L-1] = 1'b1;
                        s_lo[L-2] = 1'b0;
                    end else begin
                        for (int i = 0; i <= L - 2; i++) s_lo[i] = 1'b1;
                    end
                end
            end
        end else if (MODE == MODE_CONST) begin : g_const
            always_comb begin
                s_lo = or_vec;
                for (int i = 0; i < C; i++) s_lo[i] = 1'b1;
            end
        end else begin : g_plain
            assign s_lo = or_vec;
        end
    endgenerate

endmodule

// File: rtl/exact_ripple.sv
module exact_ripple
    import approx_pkg::*;
#(
    parameter int H = 8
) (
    input  logic [H-1:0] a_hi,
    input  logic [H-1:0] b_hi,
    input  logic         cin,
    output logic [H-1:0] s_hi,
    output logic         cout
);

    logic [H:0] cy;
    assign cy[0] = cin;

    generate
        for (genvar i = 0; i < H; i++) begin : g_cell
            assign s_hi[i]   = fa_sum(a_hi[i], b_hi[i], cy[i]);
            assign cy[i+1]   = fa_carry(a_hi[i], b_hi[i], cy[i]);
        end
    endgenerate

    assign cout = cy[H];

endmodule

// File: rtl/approx_split_adder.sv
module approx_split_adder
    import approx_pkg::*;
#(
    parameter int    N    = 16,
    parameter int    L    = 8,
    parameter mode_e MODE = MODE_HYBRID,
    parameter int    C    = 2
) (
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    output logic [N-1:0] sum_out,
    output logic         carry_out
);

    localparam int H = N - L;

    generate
        if (L < 2 || L >= N || C > L - 1) begin : g_bad_params
            $error("approx_split_adder: parameter combination out of range");
        end
    endgenerate

    logic cin_pred;

    approx_lower #(.L(L), .MODE(MODE), .C(C)) u_lower (
        .a_lo   (a_in[L-1:0]),
        .b_lo   (b_in[L-1:0]),
        .s_lo   (sum_out[L-1:0]),
        .cin_hi (cin_pred)
    );

    exact_ripple #(.H(H)) u_upper (
        .a_hi (a_in[N-1:L]),
        .b_hi (b_in[N-1:L]),
        .cin  (cin_pred),
        .s_hi (sum_out[N-1:L]),
        .cout (carry_out)
    );

endmodule

module approx_split_adder_chk
    import approx_pkg::*;
#(
    parameter int    N    = 16,
    parameter int    L    = 8,
    parameter mode_e MODE = MODE_HYBRID,
    parameter int    C    = 2
) (
    input logic [N-1:0] a_in,
    input logic [N-1:0] b_in,
    input logic [N-1:0] sum_out,
    input logic         carry_out
);

    localparam int H = N - L;

    logic         cin_exp;
    logic [H:0]   up_exp;
    logic [L-1:0] or_lo;

    assign cin_exp = (MODE == MODE_NOAND) ? 1'b0 : (a_in[L-1] & b_in[L-1]);
    assign up_exp  = {1'b0, a_in[N-1:L]} + {1'b0, b_in[N-1:L]} + {{H{1'b0}}, cin_exp};
    assign or_lo   = a_in[L-1:0] | b_in[L-1:0];

    generate
        if (MODE == MODE_NOAND) begin : g_chk_noand
            always_comb begin
                p_upper_nocarry_r4: assert ({carry_out, sum_out[N-1:L]} == up_exp);
                p_lower_or_r4: assert (sum_out[L-1:0] == or_lo);
            end
        end else begin : g_chk_pred
            always_comb begin
                // R1 and R3: exact upper part driven by AND-predicted carry
                p_upper_exact_r1: assert ({carry_out, sum_out[N-1:L]} == up_exp);
            end
        end

        if (MODE == MODE_LOA) begin : g_chk_loa
            always_comb begin
                p_lower_or_r2: assert (sum_out[L-1:0] == or_lo);
            end
        end

        if (MODE == MODE_CONST) begin : g_chk_const
            always_comb begin
                for (int i = 0; i < L; i++) begin
                    p_const_fill_r5: assert (sum_out[i] == ((i < C) ? 1'b1 : or_lo[i]));
                end
            end
        end

        if (MODE == MODE_HYBRID) begin : g_chk_hyb
            logic pair_hi;
            logic pair_eq;
            assign pair_hi = a_in[L-2] & b_in[L-2];
            assign pair_eq = (a_in[L-1] == b_in[L-1]);
            always_comb begin
                if (!pair_hi) begin
                    p_hyb_pass_r6: assert (sum_out[L-1] == (a_in[L-1] ^ b_in[L-1])
                                           && sum_out[L-2:0] == or_lo[L-2:0]);
                end
                if (pair_hi && pair_eq) begin
                    p_hyb_fix_r7: assert (sum_out[L-1] && !sum_out[L-2]);
                end
                if (pair_hi && !pair_eq) begin
                    p_hyb_sat_r8: assert (sum_out[L-1] && (&sum_out[L-2:0]));
                end
            end
        end
    endgenerate

endmodule

bind approx_split_adder approx_split_adder_chk #(
    .N(N), .L(L), .MODE(MODE), .C(C)
) u_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .sum_out   (sum_out),
    .carry_out (carry_out)
);

// File: tb/approx_split_adder_bench.sv
module approx_split_adder_bench;
    import approx_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0]  a8, b8;
    logic [15:0] a16, b16;
    logic [7:0]  s_loa, s_noa, s_cst, s_hyb;
    logic        c_loa, c_noa, c_cst, c_hyb;
    logic [15:0] s_big;
    logic        c_big;

    approx_split_adder #(.N(8), .L(4), .MODE(MODE_LOA), .C(2)) u_n8_loa (
        .a_in(a8), .b_in(b8), .sum_out(s_loa), .carry_out(c_loa));
    approx_split_adder #(.N(8), .L(4), .MODE(MODE_NOAND), .C(2)) u_n8_noand (
        .a_in(a8), .b_in(b8), .sum_out(s_noa), .carry_out(c_noa));
    approx_split_adder #(.N(8), .L(4), .MODE(MODE_CONST), .C(2)) u_n8_const (
        .a_in(a8), .b_in(b8), .sum_out(s_cst), .carry_out(c_cst));
    approx_split_adder #(.N(8), .L(4), .MODE(MODE_HYBRID), .C(2)) u_n8_hyb (
        .a_in(a8), .b_in(b8), .sum_out(s_hyb), .carry_out(c_hyb));
    approx_split_adder u_approx_split_adder (
        .a_in(a16), .b_in(b16), .sum_out(s_big), .carry_out(c_big));

    // Behavioural reference: mode 0 OR, 1 no prediction, 2 constant fill, 3 hybrid
    function automatic logic [31:0] ref_add(int mode, int l, int c,
                                            logic [31:0] a, logic [31:0] b);
        logic [31:0] lo;
        logic [31:0] hi;
        int cin;
        lo = '0;
        for (int i = 0; i < l; i++) lo[i] = a[i] | b[i];
        cin = (mode == 1) ? 0 : int'(a[l-1] & b[l-1]);
        if (mode == 2) for (int i = 0; i < c; i++) lo[i] = 1'b1;
        if (mode == 3) begin
            lo[l-1] = a[l-1] ^ b[l-1];
            if (a[l-2] && b[l-2]) begin
                if (a[l-1] == b[l-1]) begin
                    lo[l-1] = 1'b1;
                    lo[l-2] = 1'b0;
                end else begin
                    for (int i = 0; i <= l - 2; i++) lo[i] = 1'b1;
                end
            end
        end
        hi = (a >> l) + (b >> l) + 32'(cin);
        return (hi << l) | lo;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (a8=%h b8=%h a16=%h b16=%h)",
                     tag, got, exp, a8, b8, a16, b16);
        end
    endtask

    function automatic string hyb_tag(logic [7:0] a, logic [7:0] b);
        if (!(a[2] && b[2])) return "R6";
        if (a[3] == b[3])    return "R7";
        return "R8";
    endfunction

    initial begin
        // zero-operand state
        a8 = '0; b8 = '0; a16 = '0; b16 = '0;
        @(negedge clk);
        check("R2 zero", {23'd0, c_loa, s_loa}, 32'd0);
        check("R5 zero", {23'd0, c_cst, s_cst}, 32'h03);

        // directed: carry prediction at L-1 (R1, R3, R4)
        a8 = 8'h18; b8 = 8'h08;
        @(negedge clk);
        check("R3 predicted carry", {23'd0, c_loa, s_loa}, 32'h28);
        check("R4 no prediction",   {23'd0, c_noa, s_noa}, 32'h18);
        a8 = 8'hF8; b8 = 8'h18;
        @(negedge clk);
        check("R1 carry out", {23'd0, c_loa, s_loa}, 32'h118);

        // directed hybrid cases (L=4): bits 3 and 2
        a8 = 8'h0C; b8 = 8'h0D;   // both L-1 set, both L-2 set -> fix, cin=1
        @(negedge clk);
        check("R7 correct top pair", {23'd0, c_hyb, s_hyb}, 32'h19);
        a8 = 8'h04; b8 = 8'h0C;   // L-1 differs, L-2 both set -> saturate
        @(negedge clk);
        check("R8 saturate", {23'd0, c_hyb, s_hyb}, 32'h0F);
        a8 = 8'h09; b8 = 8'h02;   // no reduction -> XOR top, OR below
        @(negedge clk);
        check("R6 pass through", {23'd0, c_hyb, s_hyb}, 32'h0B);

        // exhaustive N=8 sweep
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                @(posedge clk);
                a8 = 8'(ia); b8 = 8'(ib);
                @(negedge clk);
                check("R2 sweep",  {23'd0, c_loa, s_loa}, ref_add(0, 4, 2, 32'(ia), 32'(ib)));
                check("R4 sweep",  {23'd0, c_noa, s_noa}, ref_add(1, 4, 2, 32'(ia), 32'(ib)));
                check("R5 sweep",  {23'd0, c_cst, s_cst}, ref_add(2, 4, 2, 32'(ia), 32'(ib)));
                check(hyb_tag(a8, b8), {23'd0, c_hyb, s_hyb},
                      ref_add(3, 4, 2, 32'(ia), 32'(ib)));
            end
        end

        // random N=16 hybrid
        for (int k = 0; k < 3000; k++) begin
            @(posedge clk);
            a16 = 16'($urandom); b16 = 16'($urandom);
            if (k % 4 == 0) begin a16[6] = 1'b1; b16[6] = 1'b1; end
            @(negedge clk);
            check("R1 R3 random hybrid N16", {15'd0, c_big, s_big},
                  ref_add(3, 8, 2, 32'(a16), 32'(b16)));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int cyc = 0; cyc < 190000; cyc++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule